// File: doc/BRIEF.md
# Multi-Channel Interrupt and Status Register Bank

This block is the shared register bank that sits beside a group of counter channels. It gathers one event pulse per channel into a pending-interrupt register and gates each event with a per-channel enable bit. It drives a single level interrupt and a global counter reset, and it lets the host read the channels' index levels and their differential cable health. A host reaches it over a byte-wide address/data bus with separate write and read strobes.

The low part of the address space belongs to the channels themselves. Each channel owns a data byte and a control byte there. The bank only decodes those accesses into per-channel strobes and returns the selected channel's byte. All bus pins are plain strobes with no back-pressure: an access is taken in the cycle its strobe is high. A read result appears on the next cycle and stays there until the next read. Any write to the operation register acknowledges every pending interrupt, whatever the written value.

Top module: `irqbank_top`

## Requirements
- R1: After reset the pending register, the interrupt enable mask and the operation register read as 0x00, `irq` and `cnt_reset` are low, and the cable monitor mask is all ones, so offset 0x17 reads 0xFF.
- R2: An event pulse on channel i sets bit i of the pending register (offset 0x10) only when bit i of the enable mask (offset 0x12) is set. An event on a disabled channel leaves the pending register unchanged.
- R3: Any write to offset 0x11 clears every pending bit, whatever data is written. An enabled event arriving in the same cycle as that write is kept as pending.
- R4: `irq` is high exactly while bit 2 of the operation register is 1 and at least one pending bit is set.
- R5: Bit 0 of the operation register drives `cnt_reset` (1 holds all counters in reset, 0 lets them run). Offset 0x11 reads back bits 0 and 2 as written, and the other bits as 0.
- R6: A read of offset 0x16 returns the index levels, with bit i taken from channel i.
- R7: Offset 0x17 takes a mask in which a 0 bit enables cable monitoring for that channel. A read returns bit i = 0 only when channel i is monitored and its cable-good input is low.
- R8: An access to offsets 0x00–0x0F strobes channel addr[3:1] only, with `ch_ctrl_sel` = addr[0]. A read there returns that channel's byte from `ch_rdata`.
- R9: Writes to offsets 0x10, 0x13–0x16 and 0x18–0x1F change no register. Reads of offsets 0x13–0x15 and 0x18–0x1F return 0x00.
- R10: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_rdata | output | 8 | Registered read data |
| ch_event | input | 8 | Per-channel event pulses |
| ch_index | input | 8 | Per-channel index input levels |
| ch_cable_ok | input | 8 | Per-channel cable-good bits (0 = fault) |
| ch_wr_stb | output | 8 | Per-channel write strobe for offsets 0x00–0x0F |
| ch_rd_stb | output | 8 | Per-channel read strobe for offsets 0x00–0x0F |
| ch_ctrl_sel | output | 1 | 1 selects the channel's control byte, 0 its data byte |
| ch_rdata | input | 64 | Channel bytes, channel i in bits 8i+7..8i |
| cnt_reset | output | 1 | Global counter reset level |
| irq | output | 1 | Interrupt request level |

## Verification
The bound checker watches several rules on every cycle. A pending bit may rise only after an enabled event. An acknowledging write leaves only same-cycle events pending. An acknowledging write without events drops `irq`. `cnt_reset` follows bit 0 of the last operation write. The enable mask changes only on a write to its offset. The channel strobes stay one-hot and tied to their bus strobe. Read data holds between reads. The bench scenarios cover the rest: the read views of the index levels and the cable monitor, the reserved offsets that read as zero, the channel byte mux, and the case where an event and an acknowledge land in the same cycle.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
  localparam int NCH = 8;
  localparam int DW  = 8;
  localparam int AW  = 5;
  localparam int CH_SPAN = 2 * NCH;

  localparam logic [AW-1:0] OFF_STATUS = AW'(CH_SPAN);
  localparam logic [AW-1:0] OFF_OPER   = AW'(CH_SPAN + 1);
  localparam logic [AW-1:0] OFF_IEN    = AW'(CH_SPAN + 2);
  localparam logic [AW-1:0] OFF_INDEX  = AW'(CH_SPAN + 6);
  localparam logic [AW-1:0] OFF_CABLE  = AW'(CH_SPAN + 7);

  localparam int OPER_RST_BIT = 0;
  localparam int OPER_FN_BIT  = 2;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_CHAN,
    SEL_STATUS,
    SEL_OPER,
    SEL_IEN,
    SEL_INDEX,
    SEL_CABLE
  } reg_sel_e;
endpackage

// File: rtl/irqbank_decode.sv
module irqbank_decode
  import irqbank_pkg::*;
#(
  parameter int N_CH   = NCH,
  parameter int ADDR_W = AW
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wr,
  input  logic                       rd,
  output reg_sel_e                   sel,
  output logic                       wr_oper,
  output logic                       wr_ien,
  output logic                       wr_cable,
  output logic [N_CH-1:0]            ch_wr_stb,
  output logic [N_CH-1:0]            ch_rd_stb,
  output logic [$clog2(N_CH)-1:0]    ch_idx
);
  localparam int IW = $clog2(N_CH);

  logic in_chan;

  assign in_chan = (addr < ADDR_W'(2 * N_CH));
  assign ch_idx  = addr[IW:1];

  always_comb begin
    if (in_chan) begin
      sel = SEL_CHAN;
    end else begin
      unique case (addr)
        OFF_STATUS: sel = SEL_STATUS;
        OFF_OPER:   sel = SEL_OPER;
        OFF_IEN:    sel = SEL_IEN;
        OFF_INDEX:  sel = SEL_INDEX;
        OFF_CABLE:  sel = SEL_CABLE;
        default:    sel = SEL_ZERO;
      endcase
    end
  end

  assign wr_oper  = wr && (addr == OFF_OPER);
  assign wr_ien   = wr && (addr == OFF_IEN);
  assign wr_cable = wr && (addr == OFF_CABLE);

  for (genvar g = 0; g < N_CH; g++) begin : g_stb
    assign ch_wr_stb[g] = wr && in_chan && (ch_idx == IW'(g));
    assign ch_rd_stb[g] = rd && in_chan && (ch_idx == IW'(g));
  end
endmodule

// File: rtl/irqbank_pending.sv
module irqbank_pending #(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] event_in,
  input  logic [N_CH-1:0] enable,
  input  logic            clear_all,
  output logic [N_CH-1:0] pending
);
  for (genvar g = 0; g < N_CH; g++) begin : g_bit
    logic hit;
    assign hit = event_in[g] & enable[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pending[g] <= 1'b0;
      else if (clear_all) pending[g] <= hit;
      else if (hit)       pending[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/irqbank_cable.sv
module irqbank_cable #(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [N_CH-1:0] wdata,
  input  logic [N_CH-1:0] cable_ok,
  output logic [N_CH-1:0] view
);
  logic [N_CH-1:0] off_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  off_mask <= '1;
    else if (wr) off_mask <= wdata;
  end

  assign view = off_mask | cable_ok;
endmodule

// File: rtl/irqbank_top.sv
module irqbank_top
  import irqbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NCH-1:0]    ch_event,
  input  logic [NCH-1:0]    ch_index,
  input  logic [NCH-1:0]    ch_cable_ok,
  output logic [NCH-1:0]    ch_wr_stb,
  output logic [NCH-1:0]    ch_rd_stb,
  output logic              ch_ctrl_sel,
  input  logic [NCH*DW-1:0] ch_rdata,
  output logic              cnt_reset,
  output logic              irq
);
  localparam int IW = $clog2(NCH);

  reg_sel_e          sel;
  logic              wr_oper, wr_ien, wr_cable;
  logic [IW-1:0]     ch_idx;
  logic [NCH-1:0]    ien_mask;
  logic [NCH-1:0]    pend_vec;
  logic [NCH-1:0]    cable_view;
  logic              func_en;
  logic              rst_hold;
  logic [DW-1:0]     oper_view;
  logic [DW-1:0]     rd_next;

  irqbank_decode #(.N_CH(NCH), .ADDR_W(AW)) u_decode (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .sel(sel),
    .wr_oper(wr_oper), .wr_ien(wr_ien), .wr_cable(wr_cable),
    .ch_wr_stb(ch_wr_stb), .ch_rd_stb(ch_rd_stb), .ch_idx(ch_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_en  <= 1'b0;
      rst_hold <= 1'b0;
      ien_mask <= '0;
    end else begin
      if (wr_oper) begin
        func_en  <= bus_wdata[OPER_FN_BIT];
        rst_hold <= bus_wdata[OPER_RST_BIT];
      end
      if (wr_ien) ien_mask <= bus_wdata[NCH-1:0];
    end
  end

  irqbank_pending #(.N_CH(NCH)) u_pending (
    .clk(clk), .rst_n(rst_n), .event_in(ch_event), .enable(ien_mask),
    .clear_all(wr_oper), .pending(pend_vec)
  );

  irqbank_cable #(.N_CH(NCH)) u_cable (
    .clk(clk), .rst_n(rst_n), .wr(wr_cable), .wdata(bus_wdata[NCH-1:0]),
    .cable_ok(ch_cable_ok), .view(cable_view)
  );

  always_comb begin
    oper_view = '0;
    oper_view[OPER_FN_BIT]  = func_en;
    oper_view[OPER_RST_BIT] = rst_hold;
  end

  always_comb begin
    unique case (sel)
      SEL_CHAN:   rd_next = ch_rdata[ch_idx*DW +: DW];
      SEL_STATUS: rd_next = DW'(pend_vec);
      SEL_OPER:   rd_next = oper_view;
      SEL_IEN:    rd_next = DW'(ien_mask);
      SEL_INDEX:  rd_next = DW'(ch_index);
      SEL_CABLE:  rd_next = DW'(cable_view);
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  assign ch_ctrl_sel = bus_addr[0];
  assign cnt_reset   = rst_hold;
  assign irq         = func_en & (|pend_vec);
endmodule

// File: rtl/irqbank_checker.sv
module irqbank_checker
  import irqbank_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  bus_addr,
  input logic [DW-1:0]  bus_wdata,
  input logic           bus_wr,
  input logic           bus_rd,
  input logic [DW-1:0]  bus_rdata,
  input logic [NCH-1:0] ch_event,
  input logic [NCH-1:0] ch_wr_stb,
  input logic [NCH-1:0] ch_rd_stb,
  input logic [NCH-1:0] pend_vec,
  input logic [NCH-1:0] ien_mask,
  input logic           cnt_reset,
  input logic           irq
);
  assert_pend_needs_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_vec & ~$past(pend_vec) & ~$past(ch_event & ien_mask)) == '0));

  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_OPER) |=> ((pend_vec & ~$past(ch_event & ien_mask)) == '0));

  assert_ack_drops_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_OPER && ch_event == '0) |=> !irq);

  assert_cnt_reset_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_OPER) |=> (cnt_reset == $past(bus_wdata[OPER_RST_BIT])));

  assert_mask_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFF_IEN) |=> $stable(ien_mask));

  assert_chan_strobe_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_wr_stb) && $onehot0(ch_rd_stb));

  assert_chan_strobe_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_wr_stb != '0) |-> bus_wr) and ((ch_rd_stb != '0) |-> bus_rd));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind irqbank_top irqbank_checker u_checker (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ch_event(ch_event),
  .ch_wr_stb(ch_wr_stb), .ch_rd_stb(ch_rd_stb), .pend_vec(pend_vec),
  .ien_mask(ien_mask), .cnt_reset(cnt_reset), .irq(irq)
);

// File: tb/irqbank_top_bench.sv
module irqbank_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  // each vector: {enable mask, event pattern, expected pending}
  localparam logic [23:0] VEC [NV] = '{
    {8'hFF, 8'h01, 8'h01},
    {8'h0F, 8'hF0, 8'h00},
    {8'hAA, 8'hFF, 8'hAA},
    {8'h80, 8'h80, 8'h80},
    {8'h00, 8'hFF, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [7:0]  ch_event = '0, ch_index = '0, ch_cable_ok = '0;
  logic [7:0]  ch_wr_stb, ch_rd_stb;
  logic        ch_ctrl_sel;
  logic [63:0] ch_rdata = '0;
  logic        cnt_reset, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqbank_top u_irqbank_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ch_event(ch_event), .ch_index(ch_index), .ch_cable_ok(ch_cable_ok),
    .ch_wr_stb(ch_wr_stb), .ch_rd_stb(ch_rd_stb), .ch_ctrl_sel(ch_ctrl_sel),
    .ch_rdata(ch_rdata), .cnt_reset(cnt_reset), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); ch_event = m;
    @(negedge clk); ch_event = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(5'h10, r); check("R1 status", r, 8'h00);
    bus_read(5'h11, r); check("R1 oper", r, 8'h00);
    bus_read(5'h12, r); check("R1 enable", r, 8'h00);
    bus_read(5'h17, r); check("R1 cable mask", r, 8'hFF);
    check("R1 irq", irq, 0);
    check("R1 cnt_reset", cnt_reset, 0);

    // R2 vector table
    for (int i = 0; i < NV; i++) begin
      bus_write(5'h11, 8'h00);
      bus_write(5'h12, VEC[i][23:16]);
      pulse(VEC[i][15:8]);
      bus_read(5'h10, r);
      check("R2 pending", r, VEC[i][7:0]);
    end

    // R3 clear by any value, and simultaneous event kept
    bus_write(5'h12, 8'hFF);
    pulse(8'h21);
    bus_write(5'h11, 8'h00);
    bus_read(5'h10, r); check("R3 clear", r, 8'h00);
    pulse(8'h01);
    @(negedge clk); bus_addr = 5'h11; bus_wdata = 8'h04; bus_wr = 1'b1; ch_event = 8'h08;
    @(negedge clk); bus_wr = 1'b0; ch_event = '0;
    bus_read(5'h10, r); check("R3 same-cycle event", r, 8'h08);

    // R4 irq gating
    check("R4 irq on", irq, 1);
    bus_write(5'h11, 8'h00);
    pulse(8'h02);
    check("R4 irq off when function disabled", irq, 0);
    bus_write(5'h11, 8'h04);
    check("R4 irq after ack", irq, 0);
    pulse(8'h40);
    check("R4 irq raised", irq, 1);

    // R5 counter reset bit
    bus_write(5'h11, 8'h01);
    check("R5 cnt_reset high", cnt_reset, 1);
    bus_read(5'h11, r); check("R5 readback", r, 8'h01);
    bus_write(5'h11, 8'hFF);
    bus_read(5'h11, r); check("R5 readback masked", r, 8'h05);
    bus_write(5'h11, 8'h04);
    check("R5 cnt_reset low", cnt_reset, 0);

    // R6 index levels
    ch_index = 8'hA5;
    bus_read(5'h16, r); check("R6 index", r, 8'hA5);

    // R7 cable monitor
    ch_cable_ok = 8'h3A;
    bus_write(5'h17, 8'hF0);
    bus_read(5'h17, r); check("R7 cable view", r, 8'hFA);
    bus_write(5'h17, 8'h00);
    bus_read(5'h17, r); check("R7 all monitored", r, 8'h3A);

    // R8 channel area
    ch_rdata[5*8 +: 8] = 8'h5C;
    @(negedge clk); bus_addr = 5'h0B; bus_rd = 1'b1;
    #1 check("R8 rd strobe", ch_rd_stb, 8'h20);
    check("R8 ctrl select", ch_ctrl_sel, 1);
    @(negedge clk); bus_rd = 1'b0;
    check("R8 channel byte", bus_rdata, 8'h5C);
    @(negedge clk); bus_addr = 5'h04; bus_wdata = 8'h11; bus_wr = 1'b1;
    #1 check("R8 wr strobe", ch_wr_stb, 8'h04);
    check("R8 data select", ch_ctrl_sel, 0);
    @(negedge clk); bus_wr = 1'b0;

    // R9 non-writable and reserved offsets
    bus_write(5'h12, 8'h81);
    bus_write(5'h11, 8'h00);
    pulse(8'h01);
    bus_write(5'h10, 8'h00);
    bus_read(5'h10, r); check("R9 status write ignored", r, 8'h01);
    bus_write(5'h13, 8'hFF);
    bus_write(5'h16, 8'hFF);
    bus_write(5'h18, 8'hFF);
    bus_read(5'h12, r); check("R9 enable untouched", r, 8'h81);
    bus_read(5'h17, r); check("R9 cable untouched", r, 8'h3A);
    bus_read(5'h14, r); check("R9 reserved read 0x14", r, 8'h00);
    bus_read(5'h18, r); check("R9 reserved read 0x18", r, 8'h00);
    bus_read(5'h1F, r); check("R9 reserved read 0x1F", r, 8'h00);

    // R10 read data holds
    ch_index = 8'h3C;
    bus_read(5'h16, r);
    ch_index = 8'hC3;
    repeat (3) @(negedge clk);
    check("R10 hold", bus_rdata, 8'h3C);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule